// File: doc/BRIEF.md
# UART-framed APB command bridge

This block sits between a byte-oriented serial link and a small APB segment. It collects received bytes into a fixed command frame. A frame names a target peripheral, a transfer direction, a data word and an address. The block then runs one APB transfer to the chosen peripheral and returns the 32-bit outcome as a burst of bytes for a serial transmitter. Bit-level UART timing and the peripherals themselves sit outside the block. The block covers frame collection, the APB phase sequencing, the one-hot peripheral select, the per-peripheral ready and read-data multiplexing, and byte serialisation of the result.

One command is in flight at a time. While a transfer or its reply is pending, received bytes are dropped. The address of the most recently completed command is also presented on a parallel output, so that a host can correlate each reply with its address.

Top module: `uab_apb_bridge`

## Requirements
- R1: A command is 9 bytes, most significant byte first. Byte 0 carries the target code in bits 2:1 and the direction in bit 0 (1 = write); its bits 7:3 are ignored. Bytes 1 to 4 carry the data word and bytes 5 to 8 carry the address, each most significant byte first.
- R2: Target code k (0 or 1) drives psel[k] high and every other psel bit low. paddr, pwdata and pwrite carry the frame's values for the whole transfer.
- R3: Each transfer has exactly one setup cycle (psel high, penable low), followed by access cycles with penable high.
- R4: The access phase ends only when the selected peripheral's ready bit is high. The other peripheral's ready bit has no effect, so a transfer whose target is ready after w waits lasts w+1 access cycles.
- R5: A write returns the written data word. A read returns the selected peripheral's prdata, sampled in the cycle its ready bit is high.
- R6: Target codes 2 and 3 produce no psel, a zero result and pslverr = 1. A completed transfer to a valid target leaves pslverr = 0.
- R7: The result leaves as 4 bytes, most significant first. tx_valid is high for one cycle per byte, never while tx_busy is high, and no fifth byte follows.
- R8: rsp_addr shows the address of the last completed command, including a rejected one.
- R9: Bytes received from the start of a transfer until its last reply byte is issued are discarded. The next frame is then collected cleanly.
- R10: Reset clears psel, penable, tx_valid, pslverr and rsp_addr and discards a partly received frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| paddr | output | 32 | APB address |
| pwdata | output | 32 | APB write data |
| pwrite | output | 1 | APB direction, 1 = write |
| psel | output | 2 | One-hot peripheral select |
| penable | output | 1 | APB access phase |
| pready_in | input | 2 | Ready bit from each peripheral |
| prdata_in | input | 64 | Read data, peripheral k in bits 32k+31:32k |
| pslverr | output | 1 | Last command addressed no peripheral |
| rsp_addr | output | 32 | Address of the last completed command |
| tx_byte | output | 8 | Reply byte |
| tx_valid | output | 1 | tx_byte is issued this cycle |
| tx_busy | input | 1 | Transmitter cannot take a byte |

## Verification
A wrong byte counter or a wrong shift in the frame collector shows up within one transfer: the setup cycle carries a wrong paddr, pwdata or psel, and the reply bytes differ. A sequencer stuck in, or skipping, a phase shows within a cycle as a lost setup cycle, a penable without psel, or an access phase whose length does not match the peripheral's wait count. A miscounting serialiser shows as a missing, repeated or fifth reply byte, and a faulty busy gate lets a stray byte start a false frame, which corrupts the command after it.

// File: rtl/uab_pkg.sv
package uab_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACCESS = 2'd2
   } apb_st_e;
endpackage

// File: rtl/uab_frame_asm.sv
module uab_frame_asm #(
   parameter int BYTE_W    = 8,
   parameter int CMD_BITS  = 67,
   parameter int CMD_BYTES = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic [BYTE_W-1:0]   rx_byte,
   input  logic                rx_valid,
   output logic [CMD_BITS-1:0] cmd_bits,
   output logic                cmd_vld
);
   localparam int CNT_W = $clog2(CMD_BYTES + 1);

   logic [CNT_W-1:0] cnt_q;
   logic             take;

   assign take = rx_valid && accept;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         cmd_bits <= '0;
         cmd_vld  <= 1'b0;
      end else begin
         cmd_vld <= 1'b0;
         if (take) begin
            cmd_bits <= CMD_BITS'({cmd_bits, rx_byte});
            if (cnt_q == CNT_W'(CMD_BYTES - 1)) begin
               cnt_q   <= '0;
               cmd_vld <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/uab_apb_seq.sv
module uab_apb_seq #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 2,
   parameter int NUM_SLV = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_vld,
   input  logic [SEL_W-1:0]          cmd_sel,
   input  logic                      cmd_wr,
   input  logic [DATA_W-1:0]         cmd_data,
   input  logic [ADDR_W-1:0]         cmd_addr,
   input  logic [NUM_SLV-1:0]        pready_in,
   input  logic [NUM_SLV*DATA_W-1:0] prdata_in,
   output logic [ADDR_W-1:0]         paddr,
   output logic [DATA_W-1:0]         pwdata,
   output logic                      pwrite,
   output logic [NUM_SLV-1:0]        psel,
   output logic                      penable,
   output logic                      pslverr,
   output logic [ADDR_W-1:0]         rsp_addr,
   output logic                      done,
   output logic [DATA_W-1:0]         res_word,
   output logic                      idle
);
   import uab_pkg::*;

   apb_st_e           st_q;
   logic [SEL_W-1:0]  sel_q;
   logic              sel_ok;
   logic              rdy_mux;
   logic [DATA_W-1:0] rdata_mux;

   assign sel_ok = ({1'b0, cmd_sel} < (SEL_W + 1)'(NUM_SLV));

   // ready and read data come from the latched target only
   always_comb begin
      rdy_mux   = 1'b0;
      rdata_mux = '0;
      for (int k = 0; k < NUM_SLV; k++) begin
         if (sel_q == SEL_W'(k)) begin
            rdy_mux   = pready_in[k];
            rdata_mux = prdata_in[k*DATA_W +: DATA_W];
         end
      end
   end

   generate
      for (genvar g = 0; g < NUM_SLV; g++) begin : g_psel
         assign psel[g] = (st_q != ST_IDLE) && (sel_q == SEL_W'(g));
      end
   endgenerate

   assign penable  = (st_q == ST_ACCESS);
   assign idle     = (st_q == ST_IDLE);
   assign done     = (idle && cmd_vld && !sel_ok) || (penable && rdy_mux);
   assign res_word = penable ? (pwrite ? pwdata : rdata_mux) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         sel_q    <= '0;
         paddr    <= '0;
         pwdata   <= '0;
         pwrite   <= 1'b0;
         pslverr  <= 1'b0;
         rsp_addr <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (cmd_vld) begin
                  sel_q  <= cmd_sel;
                  paddr  <= cmd_addr;
                  pwdata <= cmd_data;
                  pwrite <= cmd_wr;
                  if (sel_ok) begin
                     st_q <= ST_SETUP;
                  end else begin
                     pslverr  <= 1'b1;
                     rsp_addr <= cmd_addr;
                  end
               end
            end
            ST_SETUP: st_q <= ST_ACCESS;
            ST_ACCESS: begin
               if (rdy_mux) begin
                  st_q     <= ST_IDLE;
                  pslverr  <= 1'b0;
                  rsp_addr <= paddr;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uab_ret_ser.sv
module uab_ret_ser #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   input  logic              tx_busy,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_valid,
   output logic              active
);
   localparam int NBYTES = DATA_W / BYTE_W;
   localparam int CNT_W  = $clog2(NBYTES + 1);

   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  left_q;

   assign active   = (left_q != '0);
   assign tx_valid = active && !tx_busy;
   assign tx_byte  = sh_q[DATA_W-1 -: BYTE_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load) begin
         sh_q   <= word;
         left_q <= CNT_W'(NBYTES);
      end else if (tx_valid) begin
         sh_q   <= sh_q << BYTE_W;
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/uab_apb_bridge.sv
module uab_apb_bridge #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int SEL_W   = 2,
   parameter int NUM_SLV = 2,
   parameter int BYTE_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [BYTE_W-1:0]         rx_byte,
   input  logic                      rx_valid,
   output logic [ADDR_W-1:0]         paddr,
   output logic [DATA_W-1:0]         pwdata,
   output logic                      pwrite,
   output logic [NUM_SLV-1:0]        psel,
   output logic                      penable,
   input  logic [NUM_SLV-1:0]        pready_in,
   input  logic [NUM_SLV*DATA_W-1:0] prdata_in,
   output logic                      pslverr,
   output logic [ADDR_W-1:0]         rsp_addr,
   output logic [BYTE_W-1:0]         tx_byte,
   output logic                      tx_valid,
   input  logic                      tx_busy
);
   localparam int CMD_BITS  = SEL_W + 1 + DATA_W + ADDR_W;
   localparam int CMD_BYTES = (CMD_BITS + BYTE_W - 1) / BYTE_W;

   generate
      if (DATA_W % BYTE_W != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (NUM_SLV < 2 || NUM_SLV > (1 << SEL_W)) begin : g_bad_slaves
         $error("NUM_SLV must be between 2 and 2**SEL_W");
      end
   endgenerate

   logic [CMD_BITS-1:0] cmd_bits;
   logic                cmd_vld;
   logic                seq_done;
   logic                seq_idle;
   logic                ser_active;
   logic [DATA_W-1:0]   res_word;
   logic                accept;

   // one command in flight: frame intake closes until the reply is out
   assign accept = !cmd_vld && seq_idle && !ser_active;

   uab_frame_asm #(
      .BYTE_W   (BYTE_W),
      .CMD_BITS (CMD_BITS),
      .CMD_BYTES(CMD_BYTES)
   ) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .rx_byte (rx_byte),
      .rx_valid(rx_valid),
      .cmd_bits(cmd_bits),
      .cmd_vld (cmd_vld)
   );

   uab_apb_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W),
      .NUM_SLV(NUM_SLV)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_vld  (cmd_vld),
      .cmd_sel  (cmd_bits[CMD_BITS-1 -: SEL_W]),
      .cmd_wr   (cmd_bits[ADDR_W+DATA_W]),
      .cmd_data (cmd_bits[ADDR_W +: DATA_W]),
      .cmd_addr (cmd_bits[ADDR_W-1:0]),
      .pready_in(pready_in),
      .prdata_in(prdata_in),
      .paddr    (paddr),
      .pwdata   (pwdata),
      .pwrite   (pwrite),
      .psel     (psel),
      .penable  (penable),
      .pslverr  (pslverr),
      .rsp_addr (rsp_addr),
      .done     (seq_done),
      .res_word (res_word),
      .idle     (seq_idle)
   );

   uab_ret_ser #(
      .DATA_W(DATA_W),
      .BYTE_W(BYTE_W)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (seq_done),
      .word    (res_word),
      .tx_busy (tx_busy),
      .tx_byte (tx_byte),
      .tx_valid(tx_valid),
      .active  (ser_active)
   );
endmodule

// File: rtl/uab_checker.sv
module uab_checker #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int NUM_SLV = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  paddr,
   input logic [DATA_W-1:0]  pwdata,
   input logic               pwrite,
   input logic [NUM_SLV-1:0] psel,
   input logic               penable,
   input logic [NUM_SLV-1:0] pready_in,
   input logic               tx_valid
);
   p_psel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(psel));

   p_penable_has_psel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> (psel != '0));

   p_setup_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((psel != '0) && !penable) |=> (penable && $stable(psel) && $stable(paddr)));

   p_access_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (penable && ((psel & pready_in) == '0)) |=>
         (penable && $stable(psel) && $stable(paddr) && $stable(pwdata) && $stable(pwrite)));

   p_access_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (penable && ((psel & pready_in) != '0)) |=> (!penable && (psel == '0)));

   p_quiet_tx_during_apb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (psel != '0) |-> !tx_valid);
endmodule

bind uab_apb_bridge uab_checker #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .NUM_SLV(NUM_SLV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .paddr    (paddr),
   .pwdata   (pwdata),
   .pwrite   (pwrite),
   .psel     (psel),
   .penable  (penable),
   .pready_in(pready_in),
   .tx_valid (tx_valid)
);

// File: tb/tb_uab_apb_bridge.sv
module tb_uab_apb_bridge;
   timeunit 1ns;
   timeprecision 100ps;

   localparam logic [31:0] K0 = 32'h5A5A_0000;
   localparam logic [31:0] K1 = 32'h0000_C3C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_valid = 1'b0;
   logic [31:0] paddr, pwdata, rsp_addr;
   logic        pwrite, penable, pslverr, tx_valid;
   logic [1:0]  psel;
   logic [1:0]  pready_in = '0;
   logic [63:0] prdata_in = '0;
   logic [7:0]  tx_byte;
   logic        tx_busy = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   uab_apb_bridge dut (
      .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .paddr(paddr), .pwdata(pwdata), .pwrite(pwrite), .psel(psel),
      .penable(penable), .pready_in(pready_in), .prdata_in(prdata_in),
      .pslverr(pslverr), .rsp_addr(rsp_addr), .tx_byte(tx_byte),
      .tx_valid(tx_valid), .tx_busy(tx_busy)
   );

   // {sel[1:0], wr, data[31:0], addr[31:0], waits[3:0], gap[3:0]}
   localparam int NV = 6;
   localparam logic [74:0] VEC [NV] = '{
      {2'd0, 1'b1, 32'hDEAD_BEEF, 32'h0000_1000, 4'd0, 4'd0},
      {2'd1, 1'b0, 32'h1234_5678, 32'h8000_0004, 4'd2, 4'd0},
      {2'd0, 1'b0, 32'hCAFE_F00D, 32'h0000_0010, 4'd1, 4'd2},
      {2'd1, 1'b1, 32'hA5A5_5A5A, 32'hFFFF_FFFC, 4'd3, 4'd1},
      {2'd2, 1'b0, 32'h1111_1111, 32'h2222_2222, 4'd0, 4'd0},
      {2'd3, 1'b1, 32'h3333_3333, 32'h4444_4444, 4'd0, 4'd1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      rx_byte  = b;
      rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic run_cmd(input logic [1:0] sel, input logic wr, input logic [31:0] data,
                          input logic [31:0] addr, input int waits, input int gap, input bit junk);
      logic [71:0] fr;
      logic [31:0] exp_word, got;
      int setup_n, acc_n, nb, extra;
      bit junk_on;
      fr = {5'b10101, sel, wr, data, addr};   // pad bits set: must be ignored (R1)
      prdata_in = {addr ^ K1, addr ^ K0};
      exp_word = (sel > 2'd1) ? 32'h0 : (wr ? data : (sel == 2'd0 ? addr ^ K0 : addr ^ K1));
      setup_n = 0; acc_n = 0; nb = 0; extra = 0; got = '0; junk_on = 1'b0;
      for (int i = 0; i < 9; i++) send_byte(fr[71 - 8*i -: 8]);
      for (int cyc = 0; cyc < 120 && nb < 4; cyc++) begin
         if (psel != '0 && !penable) begin
            setup_n++;
            chk("R2 psel", {30'b0, psel}, (32'd1 << sel));
            chk("R2 paddr", paddr, addr);
            chk("R2 pwdata", pwdata, data);
            chk("R2 pwrite", {31'b0, pwrite}, {31'b0, wr});
         end
         if (penable) acc_n++;
         if (junk && psel != '0) junk_on = 1'b1;
         // the other peripheral is always ready (R4); the target waits
         pready_in = (sel == 2'd0) ? 2'b10 : 2'b01;
         if (penable && acc_n > waits) pready_in[sel[0]] = 1'b1;
         tx_busy = (gap > 0) ? ((cyc % (gap + 1)) != 0) : 1'b0;
         rx_valid = junk_on;
         rx_byte  = 8'hFF;
         #1;
         if (tx_valid) begin
            if (tx_busy) chk("R7 tx_valid while busy", 32'd1, 32'd0);
            got = {got[23:0], tx_byte};
            nb++;
            if (nb == 4) rx_valid = 1'b0;
         end
         @(negedge clk);
      end
      rx_valid = 1'b0;
      tx_busy  = 1'b0;
      pready_in = (sel == 2'd0) ? 2'b10 : 2'b01;
      for (int c = 0; c < 6; c++) begin
         #1;
         if (tx_valid) extra++;
         @(negedge clk);
      end
      chk("R7 byte count", nb, 4);
      chk("R7 no fifth byte", extra, 0);
      chk("R5 result word", got, exp_word);
      chk("R3 setup cycles", setup_n, (sel > 2'd1) ? 0 : 1);
      chk("R4 access cycles", acc_n, (sel > 2'd1) ? 0 : waits + 1);
      chk("R6 pslverr", {31'b0, pslverr}, (sel > 2'd1) ? 32'd1 : 32'd0);
      chk("R8 rsp_addr", rsp_addr, addr);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 psel reset", {30'b0, psel}, 0);
      chk("R10 penable reset", {31'b0, penable}, 0);
      chk("R10 tx_valid reset", {31'b0, tx_valid}, 0);
      chk("R10 pslverr reset", {31'b0, pslverr}, 0);
      chk("R10 rsp_addr reset", rsp_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk covering R1..R8
      for (int v = 0; v < NV; v++)
         run_cmd(VEC[v][74:73], VEC[v][72], VEC[v][71:40], VEC[v][39:8],
                 int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1'b0);

      // R9: stray bytes during a transfer and its reply are dropped
      run_cmd(2'd1, 1'b0, 32'h0BAD_0BAD, 32'h0000_0400, 2, 2, 1'b1);
      run_cmd(2'd0, 1'b1, 32'h7654_3210, 32'h0000_0020, 1, 0, 1'b0);

      // R10: reset in the middle of a frame discards the partial bytes
      for (int i = 0; i < 4; i++) send_byte(8'hEE);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 rsp_addr after reset", rsp_addr, 0);
      chk("R10 pslverr after reset", {31'b0, pslverr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_cmd(2'd1, 1'b1, 32'h0F0F_F0F0, 32'h1357_9BDF, 0, 3, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule